// File: doc/BRIEF.md
# Dual-Slope Converter Conversion Sequencer

This block is the digital timing and control core of a dual-slope integrating analog-to-digital converter. A free-running oscillator clock is divided down to a count clock. The block walks the analog switch network through three phases: zeroing the offsets, integrating the unknown input for a fixed time, and integrating a reference of opposite sign until the integrator comes back to zero. A comparator on the integrator output is the only analog feedback it receives.

The comparator level is synchronized. Its value at the last count of the fixed integration is kept as the sign of the reading and picks which reference polarity is switched in. The number of counts taken to return to zero is the magnitude, so the reading is 1000 × Vin / Vref. The zeroing phase has a variable length: it absorbs whatever the return-to-zero phase did not use, so the signal-integrate phase repeats at a fixed interval. Magnitude, sign and an overrange flag are presented together with a one-clock valid pulse.

Top module: `dsq_sequencer`

## Requirements
- R1: The count clock advances once every 4 oscillator clocks. A return-to-zero phase that ends on its count k therefore lasts 4·(k+1) clocks, from the `sw_deint` rise to the `result_valid` pulse.
- R2: Exactly one of `sw_az`, `sw_int` and `sw_deint` is high at all times. The phases always follow the order zeroing, then signal integrate, then return-to-zero, then zeroing again.
- R3: The signal-integrate phase (`sw_int` high) lasts exactly 1000 counts, which is 4000 clocks.
- R4: `cmp_in` passes through a two-flop synchronizer. The return-to-zero phase ends on the first count whose synchronized comparator level differs from the latched polarity. The reading is the number of counts completed before that count, from 0 to 1999.
- R5: The zeroing phase after a reading k lasts 2999 − k counts. The first zeroing phase after reset lasts 1000 counts.
- R6: The synchronized `cmp_in` value at the last signal-integrate count is latched as the polarity, where 1 means positive. During return-to-zero, `ref_neg` is high for a positive polarity and `ref_pos` is high for a negative one. Both are low outside that phase.
- R7: If 2000 counts pass with no crossing, the phase ends, `result_mag` becomes 1999 and `result_ovr` becomes 1. A crossing found on count 1999 gives 1999 with `result_ovr` at 0.
- R8: Consecutive rises of `sw_int` are exactly 4000 counts (16000 clocks) apart.
- R9: `result_mag`, `result_neg` (1 when the latched polarity was negative) and `result_ovr` change only in the cycle where `result_valid` pulses for one clock. That cycle is the first cycle of the following zeroing phase. The values are held otherwise.
- R10: A synchronous active-low `rst_n` forces the zeroing phase, restarts the count clock and clears all results and `result_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Integrator comparator, 1 = output above zero |
| sw_az | output | 1 | Zeroing switches closed |
| sw_int | output | 1 | Input integrate switches closed |
| sw_deint | output | 1 | Reference integrate switches closed |
| ref_pos | output | 1 | Connect the positive reference (negative input) |
| ref_neg | output | 1 | Connect the negative reference (positive input) |
| result_mag | output | 11 | Reading magnitude, 0 to 1999 |
| result_neg | output | 1 | Reading sign, 1 = negative |
| result_ovr | output | 1 | Overrange flag |
| result_valid | output | 1 | One-clock pulse when results update |

## Verification
On every cycle the assertions check the following: the switch outputs are one-hot and follow the phase order, the reference selects appear only during return-to-zero and exactly one of them is high there, results move only with the valid pulse at zeroing entry, the magnitude stays in range, and the signal-integrate phase has its exact length. Only the bench scenarios can show that the magnitude equals the crossing count under the synchronizer delay, that the sign follows the comparator at the last integrate count, the overrange and count-1999 boundaries, the variable zeroing length and fixed repetition interval, and recovery from a reset taken mid-conversion.

// File: rtl/dsq_pkg.sv
// Shared types for the dual-slope conversion sequencer.
package dsq_pkg;
    // Conversion phases, in their execution order.
    typedef enum logic [1:0] {
        PH_AZ = 2'd0,
        PH_SI = 2'd1,
        PH_DI = 2'd2
    } phase_t;
endpackage

// File: rtl/dsq_prescaler.sv
// Divides the oscillator clock into a one-cycle count-enable pulse.
// Assumes DIV >= 2. The tick is high in the last cycle of each group of DIV clocks.
module dsq_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = $clog2(DIV);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    // Tick on the last state of the divider.
    assign tick = (div_q == LAST);

    // Divider counter, wrapping every DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + DW'(1);
    end
endmodule

// File: rtl/dsq_sync2.sv
// Two-flop synchronizer for the asynchronous comparator level.
// Assumes the input is a level that is stable for several clocks around a change.
module dsq_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    // Shift the input through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dsq_phase_ctrl.sv
// Phase sequencer: zeroing, signal integrate, return-to-zero.
// Advances only on tick. Latches polarity at the last integrate count, ends
// return-to-zero on a comparator change or at the count limit, and sets the
// next zeroing length so that the integrate phase repeats every CONV_LEN counts.
// Assumes CONV_LEN >= SI_LEN + DI_MAX + 1.
module dsq_phase_ctrl
    import dsq_pkg::*;
#(
    parameter int SI_LEN   = 1000,
    parameter int DI_MAX   = 2000,
    parameter int CONV_LEN = 4000,
    localparam int MW      = $clog2(DI_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cmp_s,
    output phase_t        phase,
    output logic          pol_pos,
    output logic          done,
    output logic          done_ovr,
    output logic [MW-1:0] done_cnt
);
    localparam int CW = $clog2(CONV_LEN);
    localparam logic [CW-1:0] AZ_FIRST_LAST = CW'(CONV_LEN - SI_LEN - DI_MAX - 1);
    localparam logic [CW-1:0] AZ_BASE       = CW'(CONV_LEN - SI_LEN - 2);
    localparam logic [CW-1:0] SI_LAST       = CW'(SI_LEN - 1);
    localparam logic [CW-1:0] DI_LAST       = CW'(DI_MAX - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] az_last_q;
    logic          crossed;
    logic          di_end;

    // Crossing: the comparator has left the side latched at integrate end.
    assign crossed  = (cmp_s != pol_pos);
    assign di_end   = crossed || (cnt_q == DI_LAST);
    assign done     = tick && (phase == PH_DI) && di_end;
    assign done_ovr = !crossed;
    assign done_cnt = cnt_q[MW-1:0];

    // Phase and count register, stepped once per count tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_AZ;
            cnt_q     <= '0;
            az_last_q <= AZ_FIRST_LAST;
            pol_pos   <= 1'b0;
        end else if (tick) begin
            case (phase)
                PH_AZ: begin
                    if (cnt_q == az_last_q) begin
                        phase <= PH_SI;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                PH_SI: begin
                    if (cnt_q == SI_LAST) begin
                        pol_pos <= cmp_s;
                        phase   <= PH_DI;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                PH_DI: begin
                    if (di_end) begin
                        phase     <= PH_AZ;
                        cnt_q     <= '0;
                        az_last_q <= AZ_BASE - cnt_q;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: begin
                    phase <= PH_AZ;
                    cnt_q <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dsq_result_reg.sv
// Result holding register: loads magnitude, sign and overrange together
// and raises a one-clock valid pulse on each load.
module dsq_result_reg #(
    parameter int MW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [MW-1:0] mag_in,
    input  logic          neg_in,
    input  logic          ovr_in,
    output logic [MW-1:0] mag,
    output logic          neg,
    output logic          ovr,
    output logic          valid
);
    // Capture the reading when a conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag   <= '0;
            neg   <= 1'b0;
            ovr   <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= load;
            if (load) begin
                mag <= mag_in;
                neg <= neg_in;
                ovr <= ovr_in;
            end
        end
    end
endmodule

// File: rtl/dsq_sequencer.sv
// Top of the dual-slope conversion sequencer. Connects the prescaler, the
// comparator synchronizer, the phase controller and the result register, and
// decodes the phase into the switch and reference-select outputs.
// Assumes cmp_in high means the integrator output is above zero.
module dsq_sequencer
    import dsq_pkg::*;
#(
    parameter int DIV      = 4,
    parameter int SI_LEN   = 1000,
    parameter int DI_MAX   = 2000,
    parameter int CONV_LEN = 4000,
    localparam int MW      = $clog2(DI_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_in,
    output logic          sw_az,
    output logic          sw_int,
    output logic          sw_deint,
    output logic          ref_pos,
    output logic          ref_neg,
    output logic [MW-1:0] result_mag,
    output logic          result_neg,
    output logic          result_ovr,
    output logic          result_valid
);
    logic          tick;
    logic          cmp_s;
    phase_t        phase;
    logic          pol_pos;
    logic          done;
    logic          done_ovr;
    logic [MW-1:0] done_cnt;

    dsq_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dsq_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_in),
        .q     (cmp_s)
    );

    dsq_phase_ctrl #(
        .SI_LEN   (SI_LEN),
        .DI_MAX   (DI_MAX),
        .CONV_LEN (CONV_LEN)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmp_s    (cmp_s),
        .phase    (phase),
        .pol_pos  (pol_pos),
        .done     (done),
        .done_ovr (done_ovr),
        .done_cnt (done_cnt)
    );

    dsq_result_reg #(.MW(MW)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (done),
        .mag_in (done_cnt),
        .neg_in (!pol_pos),
        .ovr_in (done_ovr),
        .mag    (result_mag),
        .neg    (result_neg),
        .ovr    (result_ovr),
        .valid  (result_valid)
    );

    // Switch decode and opposing reference selection.
    always_comb begin
        sw_az    = (phase == PH_AZ);
        sw_int   = (phase == PH_SI);
        sw_deint = (phase == PH_DI);
        ref_neg  = sw_deint && pol_pos;
        ref_pos  = sw_deint && !pol_pos;
    end
endmodule

// File: rtl/dsq_sequencer_chk.sv
// Assertion checker for dsq_sequencer, attached with bind below.
// Watches only the top-level ports.
module dsq_sequencer_chk #(
    parameter int DIV      = 4,
    parameter int SI_LEN   = 1000,
    parameter int DI_MAX   = 2000,
    localparam int MW      = $clog2(DI_MAX)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_az,
    input logic          sw_int,
    input logic          sw_deint,
    input logic          ref_pos,
    input logic          ref_neg,
    input logic [MW-1:0] result_mag,
    input logic          result_neg,
    input logic          result_ovr,
    input logic          result_valid
);
    logic [31:0] si_clks;

    // Count clocks spent in signal integrate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            si_clks <= '0;
        else if (sw_int)
            si_clks <= si_clks + 32'd1;
        else
            si_clks <= '0;
    end

    a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sw_az, sw_int, sw_deint}) == 1);

    a_r2_order_si: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sw_int) && $past(rst_n)) |-> $past(sw_az));

    a_r2_order_di: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sw_deint) && $past(rst_n)) |-> $past(sw_int));

    a_r2_order_az: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sw_az) && $past(rst_n)) |-> $past(sw_deint));

    a_r3_si_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sw_int) && $past(rst_n)) |-> (si_clks == 32'(SI_LEN * DIV)));

    a_r6_ref_only_deint: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pos || ref_neg) |-> sw_deint);

    a_r6_ref_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        sw_deint |-> (ref_pos != ref_neg));

    a_r9_valid_at_az: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && $past(rst_n)) |-> $rose(sw_az));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!result_valid && $past(rst_n)) |-> $stable({result_mag, result_neg, result_ovr}));

    a_r7_ovr_mag: assert property (@(posedge clk) disable iff (!rst_n)
        result_ovr |-> (result_mag == MW'(DI_MAX - 1)));

    a_r4_mag_range: assert property (@(posedge clk) disable iff (!rst_n)
        result_mag <= MW'(DI_MAX - 1));
endmodule

bind dsq_sequencer dsq_sequencer_chk #(
    .DIV    (DIV),
    .SI_LEN (SI_LEN),
    .DI_MAX (DI_MAX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_az        (sw_az),
    .sw_int       (sw_int),
    .sw_deint     (sw_deint),
    .ref_pos      (ref_pos),
    .ref_neg      (ref_neg),
    .result_mag   (result_mag),
    .result_neg   (result_neg),
    .result_ovr   (result_ovr),
    .result_valid (result_valid)
);

// File: tb/dsq_sequencer_tb.sv
`timescale 1ns/1ps
// Bench for dsq_sequencer: behavioural reference model compared every clock,
// plus directed conversions with timing and value checks.
module dsq_sequencer_tb;
    localparam int DIV = 4, SI_LEN = 1000, DI_MAX = 2000, CONV_LEN = 4000;
    localparam int MW = $clog2(DI_MAX);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_in = 1'b0;
    logic sw_az, sw_int, sw_deint, ref_pos, ref_neg;
    logic [MW-1:0] result_mag;
    logic result_neg, result_ovr, result_valid;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int t_si = 0;

    always #4 clk = ~clk;

    dsq_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in),
        .sw_az(sw_az), .sw_int(sw_int), .sw_deint(sw_deint),
        .ref_pos(ref_pos), .ref_neg(ref_neg),
        .result_mag(result_mag), .result_neg(result_neg),
        .result_ovr(result_ovr), .result_valid(result_valid)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_pre = 0, m_s1 = 0, m_s2 = 0, m_ph = 0, m_n = 0, m_azlen = 1000, m_pos = 0;
    int m_mag = 0, m_neg = 0, m_ovr = 0, m_valid = 0;

    always @(posedge clk) begin
        int cs;
        bit tk;
        cyc++;
        cs = m_s2;
        m_s2 = m_s1;
        m_s1 = cmp_in;
        tk = (m_pre == DIV - 1);
        m_pre = (m_pre + 1) % DIV;
        m_valid = 0;
        if (!rst_n) begin
            m_pre = 0; m_s1 = 0; m_s2 = 0; m_ph = 0; m_n = 0;
            m_azlen = CONV_LEN - SI_LEN - DI_MAX; m_pos = 0;
            m_mag = 0; m_neg = 0; m_ovr = 0;
        end else if (tk) begin
            if (m_ph == 0) begin
                m_n++;
                if (m_n == m_azlen) begin m_ph = 1; m_n = 0; end
            end else if (m_ph == 1) begin
                m_n++;
                if (m_n == SI_LEN) begin m_pos = cs; m_ph = 2; m_n = 0; end
            end else begin
                if (cs != m_pos || m_n == DI_MAX - 1) begin
                    m_mag = m_n;
                    m_ovr = (cs == m_pos);
                    m_neg = !m_pos;
                    m_valid = 1;
                    m_azlen = CONV_LEN - SI_LEN - 1 - m_n;
                    m_ph = 0; m_n = 0;
                end else begin
                    m_n++;
                end
            end
        end
    end

    // Compare the design against the model away from the active edge.
    always @(negedge clk) begin
        if (cyc > 0) begin
            check({sw_az, sw_int, sw_deint} == {m_ph == 0, m_ph == 1, m_ph == 2},
                  "R2", "model phase", {sw_az, sw_int, sw_deint}, m_ph);
            check(ref_neg == (m_ph == 2 && m_pos == 1) && ref_pos == (m_ph == 2 && m_pos == 0),
                  "R6", "model ref select", {ref_pos, ref_neg}, m_pos);
            check(result_mag == m_mag && result_neg == m_neg && result_ovr == m_ovr,
                  "R9", "model result", result_mag, m_mag);
            check(result_valid == m_valid, "R9", "model valid", result_valid, m_valid);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 195000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // One conversion, entered during zeroing or signal integrate.
    // k < 0 means the comparator never changes (overrange).
    task automatic run_conv(input bit pos, input int k);
        int tb, tv, ts, kk, ovr;
        ovr = (k < 0);
        kk = ovr ? DI_MAX - 1 : k;
        cmp_in = pos;
        while (!sw_deint) @(negedge clk);
        tb = cyc;
        check(tb - t_si == SI_LEN * DIV, "R3", "integrate clocks", tb - t_si, SI_LEN * DIV);
        check(ref_neg == pos && ref_pos == !pos, "R6", "ref polarity", ref_neg, pos);
        if (!ovr) begin
            repeat (DIV * k) @(posedge clk);
            @(negedge clk);
            cmp_in = !pos;
        end
        while (!result_valid) @(negedge clk);
        tv = cyc;
        check(result_mag == kk, ovr ? "R7" : "R4", "magnitude", result_mag, kk);
        check(result_neg == !pos, "R9", "sign", result_neg, !pos);
        check(result_ovr == ovr, "R7", "overrange", result_ovr, ovr);
        check(tv - tb == DIV * (kk + 1), "R1", "deintegrate clocks", tv - tb, DIV * (kk + 1));
        check(sw_az == 1'b1, "R9", "valid at zeroing entry", sw_az, 1);
        @(negedge clk);
        check(result_valid == 1'b0, "R9", "valid pulse width", result_valid, 0);
        while (!sw_int) @(negedge clk);
        ts = cyc;
        check(ts - tv == DIV * (CONV_LEN - SI_LEN - 1 - kk), "R5", "zeroing clocks",
              ts - tv, DIV * (CONV_LEN - SI_LEN - 1 - kk));
        check(ts - t_si == DIV * CONV_LEN, "R8", "integrate repeat clocks", ts - t_si, DIV * CONV_LEN);
        t_si = ts;
    endtask

    initial begin
        int t0;
        repeat (5) @(negedge clk);
        check(sw_az && !sw_int && !sw_deint, "R10", "reset phase", sw_az, 1);
        check(result_valid == 0 && result_mag == 0, "R10", "reset result", result_mag, 0);
        rst_n = 1'b1;
        t0 = cyc;
        while (!sw_int) @(negedge clk);
        check(cyc - t0 == DIV * (CONV_LEN - SI_LEN - DI_MAX), "R5", "first zeroing clocks",
              cyc - t0, DIV * (CONV_LEN - SI_LEN - DI_MAX));
        t_si = cyc;

        run_conv(1'b1, 500);
        run_conv(1'b0, 1234);
        run_conv(1'b1, 0);
        run_conv(1'b0, -1);
        run_conv(1'b1, 1999);
        run_conv(1'b0, 3);

        // R10: reset in the middle of return-to-zero.
        cmp_in = 1'b1;
        while (!sw_deint) @(negedge clk);
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sw_az && !sw_deint && !ref_pos && !ref_neg, "R10", "mid-run reset phase", sw_az, 1);
        check(result_mag == 0 && !result_neg && !result_ovr && !result_valid,
              "R10", "mid-run reset result", result_mag, 0);
        rst_n = 1'b1;
        t0 = cyc;
        while (!sw_int) @(negedge clk);
        check(cyc - t0 == DIV * (CONV_LEN - SI_LEN - DI_MAX), "R10", "restart zeroing clocks",
              cyc - t0, DIV * (CONV_LEN - SI_LEN - DI_MAX));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule